// File: doc/BRIEF.md
# Bidirectional I/O Port with Change-Detect Interrupt

This block is an 8-bit general-purpose I/O port that sits on a simple single-cycle register bus. Software sets the direction of each pin and the value driven on output pins. It reads back either the output latch or the synchronized pin levels. The block drives a per-pin output enable, a per-pin output value and a per-pin weak pull-up enable toward the pad ring. All eight pull-ups share one active-low control bit, and the pull-up on any pin configured as an output is forced off.

The upper four pins can raise a change interrupt. A pin takes part only while it is an input. Each such pin is compared with a snapshot of its synchronized level. The snapshot is refreshed on every read or write of the pin-data address. Any difference sets a sticky flag, and the flag is sent to the interrupt output when the interrupt enable is set. While a difference remains, the flag cannot be cleared. Software first reads or writes the pin-data address, which ends the difference, and then writes 0 to the flag bit.

The bus has no wait states. A read returns combinational data in the same cycle as `bus_rd`, and a write takes effect at the next rising clock edge. The bus carries register accesses only, so it has no valid/ready back-pressure.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset all pins are inputs (direction reads 0xFF, `pad_oe` = 0), the output latch is 0x00, the pull-ups are off (`pad_pull` = 0, control bit 0 reads 1), the interrupt enable and the flag are 0, and `irq` is 0.
- R2: The direction register is at address 2. Bit value 1 makes a pin an input and 0 makes it an output, so `pad_oe` is the inverse of the direction register. Writing 0xCF gives `pad_oe` = 0x30.
- R3: A write to address 0 or to address 1 loads the output latch. `pad_out` always equals the latch, and a read of address 1 returns it.
- R4: A read of address 0 returns the pin levels after a two-flop synchronizer. This is the value `pad_in` had before the last two rising edges.
- R5: Control register (address 3) bit 0 is an active-low pull-up enable shared by all pins. `pad_pull[i]` is 1 only when that bit is 0 and pin i is an input.
- R6: Only pins 7..4 that are configured as inputs take part in change detection. Changes on pins 3..0, or on pins configured as outputs, never set the flag.
- R7: Every read or write of address 0 captures the synchronized levels of pins 7..4 as the snapshot. A participating pin that differs from its snapshot sets the flag at the third rising edge after the change on `pad_in`.
- R8: The flag is control bit 2 and is sticky. Writing the control register with bit 2 = 0 clears it, and writing bit 2 = 1 has no effect. If a difference is present in the cycle of the clearing write, the flag stays set.
- R9: `irq` equals the flag ANDed with the interrupt enable (control bit 1). The flag still sets while the enable is 0.
- R10: A read of address 3 returns {5'b0, flag, enable, pull-up-off bit}. A read of address 2 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pull | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt request |

## Verification
A wrong snapshot or a wrong direction mask appears at `irq` and at control bit 2. The flag then rises three edges after a pin change when it should stay low, or stays low when it should rise. It may also stay set after the port access and clearing write that should release it. A slip in the synchronizer depth shifts the address-0 read data and the flag timing by whole cycles, and a cycle-accurate model catches this within the first pin change. Register decode faults show up at once on `pad_oe`, `pad_out` or `pad_pull`, which are compared every cycle.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PIN = 2'd0;
  localparam logic [ADDR_W-1:0] A_LAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIR = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd3;

  localparam int CTL_NPU = 0;
  localparam int CTL_IE  = 1;
  localparam int CTL_FLG = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_chg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  input  logic              flag,
  output logic [W-1:0]      lat_q,
  output logic [W-1:0]      dir_q,
  output logic              npu_q,
  output logic              ie_q,
  output logic              clr_req,
  output logic              port_acc
);
  logic wr_lat, wr_dir, wr_ctl;

  assign wr_lat   = bus_wr && (bus_addr == A_PIN || bus_addr == A_LAT);
  assign wr_dir   = bus_wr && (bus_addr == A_DIR);
  assign wr_ctl   = bus_wr && (bus_addr == A_CTL);
  assign clr_req  = wr_ctl && !bus_wdata[CTL_FLG];
  assign port_acc = (bus_wr || bus_rd) && (bus_addr == A_PIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      npu_q <= 1'b1;
      ie_q  <= 1'b0;
    end else begin
      if (wr_lat) lat_q <= bus_wdata;
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_ctl) begin
        npu_q <= bus_wdata[CTL_NPU];
        ie_q  <= bus_wdata[CTL_IE];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PIN: bus_rdata = pin_sync;
      A_LAT: bus_rdata = lat_q;
      A_DIR: bus_rdata = dir_q;
      default: begin
        bus_rdata[CTL_NPU] = npu_q;
        bus_rdata[CTL_IE]  = ie_q;
        bus_rdata[CTL_FLG] = flag;
      end
    endcase
  end

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata));

  // R3
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PIN) |=> lat_q == $past(bus_wdata));
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_hi,
  input  logic [N-1:0] dir_hi,
  input  logic         port_acc,
  input  logic         clr_req,
  output logic         mismatch,
  output logic         flag
);
  logic [N-1:0] snap_q;
  logic [N-1:0] diff;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign diff[i] = dir_hi[i] & (pin_hi[i] ^ snap_q[i]);
  end

  assign mismatch = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (port_acc) snap_q <= pin_hi;
      if (mismatch)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |=> snap_q == $past(pin_hi));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mismatch && !clr_req) |=> flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !mismatch) |=> !flag);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int W        = 8,
  parameter int CHG_LO   = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pull,
  output logic              irq
);
  localparam int NCHG = W - CHG_LO;

  logic [W-1:0] pin_sync, lat_q, dir_q;
  logic npu_q, ie_q, clr_req, port_acc, mismatch, flag;

  gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync), .flag(flag), .lat_q(lat_q), .dir_q(dir_q),
    .npu_q(npu_q), .ie_q(ie_q), .clr_req(clr_req), .port_acc(port_acc)
  );

  gpio_chg_det #(.N(NCHG)) u_chg (
    .clk(clk), .rst_n(rst_n), .pin_hi(pin_sync[W-1:CHG_LO]),
    .dir_hi(dir_q[W-1:CHG_LO]), .port_acc(port_acc), .clr_req(clr_req),
    .mismatch(mismatch), .flag(flag)
  );

  assign pad_oe   = ~dir_q;
  assign pad_out  = lat_q;
  assign pad_pull = dir_q & {W{~npu_q}};
  assign irq      = flag & ie_q;

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> flag);
endmodule

// File: tb/sim_gpio_chg_port.sv
module sim_gpio_chg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_oe, pad_out, pad_pull;
  logic       irq;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  gpio_chg_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull(pad_pull), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] m_dir, m_lat;
  logic       m_npu, m_ie, m_flag;
  logic [3:0] m_snap;
  logic [7:0] hist[$];

  function automatic logic [7:0] m_sync();
    return (hist.size() == 2) ? hist[0] : 8'h00;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_sync();
      2'd1: return m_lat;
      2'd2: return m_dir;
      default: return {5'b0, m_flag, m_ie, m_npu};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 8'hFF; m_lat = 8'h00; m_npu = 1'b1; m_ie = 1'b0;
      m_flag = 1'b0; m_snap = 4'h0; hist.delete();
    end else begin
      logic [7:0] cur;
      bit diff;
      cur  = m_sync();
      diff = 0;
      for (int i = 4; i < 8; i++)
        if (m_dir[i] && (cur[i] != m_snap[i-4])) diff = 1;
      if (diff) m_flag = 1'b1;
      else if (bus_wr && bus_addr == 2'd3 && !bus_wdata[2]) m_flag = 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          2'd0, 2'd1: m_lat = bus_wdata;
          2'd2: m_dir = bus_wdata;
          default: begin m_npu = bus_wdata[0]; m_ie = bus_wdata[1]; end
        endcase
      end
      if ((bus_wr || bus_rd) && bus_addr == 2'd0) m_snap = cur[7:4];
      hist.push_back(pad_in);
      if (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      check("R2 pad_oe model", pad_oe, ~m_dir);
      check("R3 pad_out model", pad_out, m_lat);
      check("R5 pad_pull model", pad_pull, m_dir & {8{~m_npu}});
      check("R9 irq model", {7'b0, irq}, {7'b0, m_flag & m_ie});
      if (bus_rd) check("R4/R10 rdata model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    cmp_on = 1;
    #2;
    // R1 reset state
    check("R1 pad_oe reset", pad_oe, 8'h00);
    check("R1 pad_pull reset", pad_pull, 8'h00);
    check("R1 pad_out reset", pad_out, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);
    bus_read(2'd2, 8'hFF, "R1 dir reset");
    bus_read(2'd3, 8'h01, "R1 ctl reset");

    // R2 direction
    bus_write(2'd2, 8'hCF);
    #2 check("R2 pad_oe after CF", pad_oe, 8'h30);
    bus_read(2'd2, 8'hCF, "R10 dir readback");

    // R3 latch via both addresses
    bus_write(2'd0, 8'hA5);
    bus_read(2'd1, 8'hA5, "R3 latch via port addr");
    bus_write(2'd1, 8'h3C);
    #2 check("R3 pad_out", pad_out, 8'h3C);

    // R5 pull-ups on, R9 enable
    bus_write(2'd3, 8'h02);
    #2 check("R5 pull on inputs only", pad_pull, 8'hCF);

    // R6 low pins and output pins ignored
    pad_in = 8'h0F;
    idle(5);
    bus_read(2'd3, 8'h02, "R6 low pins no flag");
    pad_in = 8'h2F;
    idle(5);
    bus_read(2'd3, 8'h02, "R6 output pin no flag");
    bus_read(2'd0, 8'h2F, "R4 synced pins read");

    // R7 flag timing on pin 6
    @(negedge clk);
    pad_in = 8'h6F;
    @(negedge clk);
    @(negedge clk);
    #2 check("R7 no flag after 2 edges", {7'b0, irq}, 8'h00);
    @(negedge clk);
    #2 check("R7 flag after 3 edges", {7'b0, irq}, 8'h01);

    // R8 clear blocked while mismatch persists
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, 8'h06, "R8 clear blocked by mismatch");
    // port read refreshes snapshot, then clear works
    bus_read(2'd0, 8'h6F, "R4 read refreshes snapshot");
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, 8'h02, "R8 clear after snapshot");
    bus_write(2'd3, 8'h06);
    bus_read(2'd3, 8'h02, "R8 writing 1 no effect");

    // R9 enable gating
    bus_write(2'd3, 8'h00);
    pad_in = 8'hEF;
    idle(4);
    #2 check("R9 irq gated off", {7'b0, irq}, 8'h00);
    bus_read(2'd3, 8'h04, "R9 flag set while disabled");
    bus_write(2'd3, 8'h06);
    #2 check("R9 irq when enabled", {7'b0, irq}, 8'h01);

    // R7 port write refreshes snapshot
    bus_write(2'd0, 8'h11);
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, 8'h02, "R7 write access refreshes snapshot");
    #2 check("R3 pad_out after port write", pad_out, 8'h11);

    // R6 upper pins as outputs are excluded
    bus_write(2'd2, 8'h0F);
    pad_in = 8'h0F;
    idle(5);
    bus_read(2'd3, 8'h02, "R6 output upper pins no flag");
    #2 check("R5 pull forced off on outputs", pad_pull, 8'h0F);
    bus_write(2'd3, 8'h03);
    #2 check("R5 pull-ups disabled", pad_pull, 8'h00);

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule